// File: doc/BRIEF.md
# Instruction Line Request Unit with Shared Retry Slot

This block sits between a multi-threaded fetch controller and the instruction cache. Each thread owns one line buffer holding a line address tag, a valid bit and the line bytes. When the controller asks for a fetch address, the block clears the address's offset bits to get the line address. If the thread's buffer already holds that line, the fetch succeeds at once. Otherwise the block invalidates the buffer, retags it with the new line address, and sends a line request to the cache over a valid/ready channel.

If the cache does not raise ready for a request, the block parks that request in one retry slot shared by all threads and raises a global blocked flag. While the flag is up, every thread's fetch is refused. A retry pulse from the cache replays the parked request. A retry pulse with nothing parked just drops the flag. A squash of a thread clears that thread's pending state. If the thread owns the parked request, the squash also purges it.

Each request carries a tag made of the thread index and a per-thread sequence bit. The sequence bit flips on every squash, so a late response to a squashed request is recognised and discarded. Address translation is outside the block and is assumed never to fault.

Top module: `lineFetchUnit`

## Requirements
- R1: After reset every line buffer is invalid, the blocked flag is low, the retry slot is empty and no cache request is presented.
- R2: A fresh request's address equals the fetch address with its low log2(LINE_BYTES) bits cleared. Its tag is {thread index, thread sequence bit}, with the sequence bit in bit 0 and the thread index in the bits above it.
- R3: A fetch whose thread buffer is valid and holds the aligned line address succeeds (fetchOk high in the same cycle) and presents no cache request.
- R4: A fetch that misses presents a request in the same cycle. If icReqReady is high, fetchOk is high and the thread's buffer reads invalid from the next cycle. Later fetches from that thread are refused, with no request, until its response arrives.
- R5: No request is made and fetchOk stays low while the blocked flag is up, while switchedOut is high, or while intPending is high and fetch address bits [1:0] are zero, even on a buffer match. With intPending high and those bits nonzero, the fetch proceeds normally.
- R6: A fresh request presented while icReqReady is low gives fetchOk low, parks the request and raises icBlocked from the next cycle. Fetches from every thread are then refused.
- R7: A retry pulse with a parked request presents the same address and tag in that cycle. If accepted, icBlocked drops in the next cycle. If refused again, icBlocked stays high.
- R8: A retry pulse with an empty slot presents no request and clears icBlocked from the next cycle.
- R9: A squash of the slot's owner purges the slot, so a later retry presents nothing, while icBlocked stays high until that retry. The sequence bit of the squashed thread flips.
- R10: A response whose tag matches a thread waiting for a response, with a matching sequence bit, stores the line. From the next cycle the buffer is valid, lineRdData shows the line, and a fetch within that line hits.
- R11: A response whose sequence bit differs from the thread's current bit, or whose thread is not waiting, is discarded and the buffer stays invalid.
- R12: A squash takes priority over a fetch and over a response for the same thread in the same cycle: the fetch is refused with no request, and the response is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch attempt this cycle |
| fetchTid | input | TID_W | Thread of the fetch; also selects lineRdData |
| fetchAddr | input | ADDR_W | Byte address to fetch |
| switchedOut | input | 1 | Stage switched out, hold off requests |
| intPending | input | 1 | Interrupt pending, gates requests by address bits [1:0] |
| squashValid | input | 1 | Squash a thread this cycle |
| squashTid | input | TID_W | Thread being squashed |
| fetchOk | output | 1 | Fetch succeeded (hit or accepted request) |
| lineRdData | output | LINE_W | Buffered line of thread fetchTid |
| lineValidVec | output | NUM_THREADS | Per-thread buffer valid bits |
| icBlocked | output | 1 | Global blocked flag |
| icReqValid | output | 1 | Line request valid |
| icReqReady | input | 1 | Cache accepts the request |
| icReqAddr | output | ADDR_W | Line-aligned request address |
| icReqTag | output | TAG_W | {thread, sequence bit} |
| icRetry | input | 1 | Cache can accept a retried request |
| icRspValid | input | 1 | Line response valid |
| icRspTag | input | TAG_W | Tag of the response |
| icRspData | input | LINE_W | Returned line bytes |

## Verification
The state that is hardest to reach from the ports is the blocked flag standing with an empty slot. This happens only when the owner of a parked request is squashed before the cache retries. The bench gets there by refusing a fresh request, squashing its thread, and checking that icBlocked stays high and that the next retry presents nothing. Stale responses are another awkward case. The bench produces them by squashing a thread that is waiting for a response, then returning the old tag both before and after the thread has reissued under its flipped sequence bit.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

  typedef enum logic [1:0] {
    TS_IDLE       = 2'd0,
    TS_WAIT_RETRY = 2'd1,
    TS_WAIT_RESP  = 2'd2
  } thrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;      // retag + invalidate buffer of issueTid
    logic fill;       // write response line into buffer of fillTid
    logic resendSel;  // request address comes from the parked thread's tag
  } dpStrobe_t;

endpackage

// File: rtl/lfu_datapath.sv
module lfu_datapath
  import lfu_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [TID_W-1:0]       issueTid,
  input  logic [TID_W-1:0]       fillTid,
  input  logic [TID_W-1:0]       slotTid,
  input  logic [TID_W-1:0]       fetchTid,
  input  logic [ADDR_W-1:0]      fetchAddr,
  input  logic [LINE_W-1:0]      rspData,
  output logic                   hit,
  output logic [ADDR_W-1:0]      reqAddr,
  output logic [LINE_W-1:0]      rdData,
  output logic [NUM_THREADS-1:0] validVec
);

  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0] lineTag  [NUM_THREADS];
  logic [LINE_W-1:0] lineData [NUM_THREADS];
  logic [NUM_THREADS-1:0] lineValid;
  logic [ADDR_W-1:0] alignedAddr;

  assign alignedAddr = fetchAddr & ~OFS_MASK;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : gBuf
    logic issueMe;
    logic fillMe;
    assign issueMe = strobe.issue && (int'(issueTid) == t);
    assign fillMe  = strobe.fill  && (int'(fillTid)  == t);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineValid[t] <= 1'b0;
        lineTag[t]   <= '0;
      end else if (issueMe) begin
        lineValid[t] <= 1'b0;
        lineTag[t]   <= alignedAddr;
      end else if (fillMe) begin
        lineValid[t] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fillMe) lineData[t] <= rspData;
    end

    // R4: an issued request leaves the buffer invalid
    a_r4_issue_invalidates: assert property (@(posedge clk) disable iff (!rstN)
      issueMe |=> !lineValid[t]);
  end

  always_comb begin
    hit    = 1'b0;
    rdData = '0;
    if (int'(fetchTid) < NUM_THREADS) begin
      hit    = lineValid[fetchTid] && (lineTag[fetchTid] == alignedAddr);
      rdData = lineData[fetchTid];
    end
  end

  always_comb begin
    reqAddr = alignedAddr;
    if (strobe.resendSel && int'(slotTid) < NUM_THREADS) reqAddr = lineTag[slotTid];
  end

  assign validVec = lineValid;

  // R2: every request address is line aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue || strobe.resendSel) |-> ((reqAddr & OFS_MASK) == '0));

endmodule

// File: rtl/lfu_ctrl.sv
module lfu_ctrl
  import lfu_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int TAG_W      = TID_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchReq,
  input  logic [TID_W-1:0] fetchTid,
  input  logic [1:0]       fetchLowBits,
  input  logic             switchedOut,
  input  logic             intPending,
  input  logic             squashValid,
  input  logic [TID_W-1:0] squashTid,
  input  logic             hit,
  input  logic             icReqReady,
  input  logic             icRetry,
  input  logic             icRspValid,
  input  logic [TAG_W-1:0] icRspTag,
  output dpStrobe_t        strobe,
  output logic [TID_W-1:0] fillTid,
  output logic [TID_W-1:0] slotTidOut,
  output logic             fetchOk,
  output logic             icReqValid,
  output logic [TAG_W-1:0] icReqTag,
  output logic             blockedOut
);

  thrState_t thrState [NUM_THREADS];
  logic [NUM_THREADS-1:0] seqBit;

  logic             blocked;
  logic             slotValid;
  logic [TID_W-1:0] slotTid;
  logic             slotSeq;

  logic inhibit, fetchLive, freshIssue, slotKill, resend, rspAccept;
  logic squashFetchTid;
  logic [TID_W-1:0] rspTid;
  logic             rspSeq;
  logic             fetchIdle;

  assign rspTid = icRspTag[TAG_W-1:1];
  assign rspSeq = icRspTag[0];

  assign inhibit = blocked || switchedOut || (intPending && fetchLowBits == 2'b00);
  assign squashFetchTid = squashValid && (squashTid == fetchTid);
  assign fetchIdle = (int'(fetchTid) < NUM_THREADS) && (thrState[fetchTid] == TS_IDLE);
  assign fetchLive  = fetchReq && !squashFetchTid && fetchIdle && !inhibit;
  assign freshIssue = fetchLive && !hit;
  assign slotKill   = squashValid && slotValid && (squashTid == slotTid);
  assign resend     = icRetry && slotValid && !slotKill;

  assign rspAccept = icRspValid && (int'(rspTid) < NUM_THREADS)
                     && (thrState[rspTid] == TS_WAIT_RESP)
                     && (seqBit[rspTid] == rspSeq)
                     && !(squashValid && squashTid == rspTid);

  assign icReqValid = freshIssue || resend;
  assign icReqTag   = resend ? {slotTid, slotSeq} : {fetchTid, seqBit[fetchTid]};
  assign fetchOk    = fetchLive && (hit || icReqReady);

  assign strobe.issue     = freshIssue;
  assign strobe.fill      = rspAccept;
  assign strobe.resendSel = resend;
  assign fillTid    = rspTid;
  assign slotTidOut = slotTid;
  assign blockedOut = blocked;

  // shared retry slot and blocked flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blocked   <= 1'b0;
      slotValid <= 1'b0;
      slotTid   <= '0;
      slotSeq   <= 1'b0;
    end else begin
      if (freshIssue && !icReqReady) begin
        blocked   <= 1'b1;
        slotValid <= 1'b1;
        slotTid   <= fetchTid;
        slotSeq   <= seqBit[fetchTid];
      end else if (slotKill) begin
        slotValid <= 1'b0;
        if (icRetry) blocked <= 1'b0;
      end else if (icRetry && !slotValid) begin
        blocked <= 1'b0;
      end else if (resend && icReqReady) begin
        slotValid <= 1'b0;
        blocked   <= 1'b0;
      end
    end
  end

  // per-thread request state and sequence bit
  for (genvar t = 0; t < NUM_THREADS; t++) begin : gThr
    logic squashMe, issueMe, resendMe, fillMe;
    assign squashMe = squashValid && (int'(squashTid) == t);
    assign issueMe  = freshIssue && (int'(fetchTid) == t);
    assign resendMe = resend && icReqReady && (int'(slotTid) == t);
    assign fillMe   = rspAccept && (int'(rspTid) == t);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        thrState[t] <= TS_IDLE;
        seqBit[t]   <= 1'b0;
      end else if (squashMe) begin
        thrState[t] <= TS_IDLE;
        seqBit[t]   <= ~seqBit[t];
      end else if (issueMe) begin
        thrState[t] <= icReqReady ? TS_WAIT_RESP : TS_WAIT_RETRY;
      end else if (resendMe) begin
        thrState[t] <= TS_WAIT_RESP;
      end else if (fillMe) begin
        thrState[t] <= TS_IDLE;
      end
    end
  end

  logic [NUM_THREADS-1:0] waitRetryVec;
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) waitRetryVec[t] = (thrState[t] == TS_WAIT_RETRY);
  end

  // R6: a parked request always keeps the stage blocked
  a_r6_slot_blocks: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |-> blocked);
  // R6: at most one thread waits for a retry, and only with a parked request
  a_r6_one_waiter: assert property (@(posedge clk) disable iff (!rstN)
    $countones(waitRetryVec) == (slotValid ? 1 : 0));
  // R5: while blocked the only request is the replay
  a_r5_blocked_no_fresh: assert property (@(posedge clk) disable iff (!rstN)
    (icReqValid && blocked) |-> (slotValid && icRetry));
  // R9: squash of the owner leaves the slot empty
  a_r9_squash_purges: assert property (@(posedge clk) disable iff (!rstN)
    slotKill |=> !slotValid);
  // R7: an accepted replay unblocks
  a_r7_replay_unblocks: assert property (@(posedge clk) disable iff (!rstN)
    (resend && icReqReady) |=> !blocked);
  // R3: a hit never requests
  a_r3_hit_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (fetchLive && hit) |-> !icReqValid);

endmodule

// File: rtl/lineFetchUnit.sv
module lineFetchUnit
  import lfu_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int TAG_W      = TID_W + 1,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fetchReq,
  input  logic [TID_W-1:0]       fetchTid,
  input  logic [ADDR_W-1:0]      fetchAddr,
  input  logic                   switchedOut,
  input  logic                   intPending,
  input  logic                   squashValid,
  input  logic [TID_W-1:0]       squashTid,
  output logic                   fetchOk,
  output logic [LINE_W-1:0]      lineRdData,
  output logic [NUM_THREADS-1:0] lineValidVec,
  output logic                   icBlocked,
  output logic                   icReqValid,
  input  logic                   icReqReady,
  output logic [ADDR_W-1:0]      icReqAddr,
  output logic [TAG_W-1:0]       icReqTag,
  input  logic                   icRetry,
  input  logic                   icRspValid,
  input  logic [TAG_W-1:0]       icRspTag,
  input  logic [LINE_W-1:0]      icRspData
);

  dpStrobe_t        strobe;
  logic             hit;
  logic [TID_W-1:0] fillTid;
  logic [TID_W-1:0] slotTid;

  lfu_ctrl #(.NUM_THREADS(NUM_THREADS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .fetchReq(fetchReq), .fetchTid(fetchTid), .fetchLowBits(fetchAddr[1:0]),
    .switchedOut(switchedOut), .intPending(intPending),
    .squashValid(squashValid), .squashTid(squashTid),
    .hit(hit), .icReqReady(icReqReady), .icRetry(icRetry),
    .icRspValid(icRspValid), .icRspTag(icRspTag),
    .strobe(strobe), .fillTid(fillTid), .slotTidOut(slotTid),
    .fetchOk(fetchOk), .icReqValid(icReqValid), .icReqTag(icReqTag),
    .blockedOut(icBlocked)
  );

  lfu_datapath #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueTid(fetchTid), .fillTid(fillTid), .slotTid(slotTid),
    .fetchTid(fetchTid), .fetchAddr(fetchAddr), .rspData(icRspData),
    .hit(hit), .reqAddr(icReqAddr), .rdData(lineRdData), .validVec(lineValidVec)
  );

endmodule

// File: tb/tb_lineFetchUnit.sv
module tb_lineFetchUnit;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int AW = 32;
  localparam int LB = 16;
  localparam int LW = LB * 8;

  logic clk = 1'b0;
  logic rstN;
  logic fetchReq, switchedOut, intPending, squashValid;
  logic [0:0] fetchTid, squashTid;
  logic [AW-1:0] fetchAddr;
  logic fetchOk, icBlocked, icReqValid, icReqReady, icRetry, icRspValid;
  logic [LW-1:0] lineRdData, icRspData;
  logic [NT-1:0] lineValidVec;
  logic [AW-1:0] icReqAddr;
  logic [1:0] icReqTag, icRspTag;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lineFetchUnit #(.NUM_THREADS(NT), .ADDR_W(AW), .LINE_BYTES(LB)) dut (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchTid(fetchTid), .fetchAddr(fetchAddr),
    .switchedOut(switchedOut), .intPending(intPending), .squashValid(squashValid),
    .squashTid(squashTid), .fetchOk(fetchOk), .lineRdData(lineRdData),
    .lineValidVec(lineValidVec), .icBlocked(icBlocked), .icReqValid(icReqValid),
    .icReqReady(icReqReady), .icReqAddr(icReqAddr), .icReqTag(icReqTag), .icRetry(icRetry),
    .icRspValid(icRspValid), .icRspTag(icRspTag), .icRspData(icRspData)
  );

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // next cycle: drive idle inputs at the falling edge
  task automatic idle();
    @(negedge clk);
    fetchReq = 0; fetchTid = 0; fetchAddr = '0; switchedOut = 0; intPending = 0;
    squashValid = 0; squashTid = 0; icReqReady = 1; icRetry = 0;
    icRspValid = 0; icRspTag = '0; icRspData = '0;
    #1;
  endtask

  task automatic doFetch(input logic [0:0] tid, input logic [AW-1:0] a, input logic rdy);
    idle();
    fetchReq = 1; fetchTid = tid; fetchAddr = a; icReqReady = rdy;
    #1;
  endtask

  task automatic doRsp(input logic [1:0] tag, input logic [LW-1:0] d);
    idle();
    icRspValid = 1; icRspTag = tag; icRspData = d;
    #1;
  endtask

  task automatic tReset();
    chkEq("R1 valid", LW'(lineValidVec), '0);
    chkEq("R1 blocked", LW'(icBlocked), 0);
    chkEq("R1 reqValid", LW'(icReqValid), 0);
  endtask

  task automatic tMissHit();
    logic [LW-1:0] d1 = {4{32'hA5A5_0001}};
    doFetch(0, 32'h1234_5678, 1);
    chkEq("R4 req", LW'(icReqValid), 1);
    chkEq("R2 addr", LW'(icReqAddr), LW'(32'h1234_5670));
    chkEq("R2 tag", LW'(icReqTag), LW'(2'b00));
    chkEq("R4 ok", LW'(fetchOk), 1);
    doFetch(0, 32'h1234_5678, 1);
    chkEq("R4 invalid", LW'(lineValidVec[0]), 0);
    chkEq("R4 busy refused", LW'({fetchOk, icReqValid}), 0);
    doRsp(2'b00, d1);
    idle();
    chkEq("R10 valid", LW'(lineValidVec[0]), 1);
    chkEq("R10 data", lineRdData, d1);
    doFetch(0, 32'h1234_567C, 1);
    chkEq("R3 hit ok", LW'(fetchOk), 1);
    chkEq("R3 no req", LW'(icReqValid), 0);
  endtask

  task automatic tInhibit();
    doFetch(0, 32'h1234_5674, 1); switchedOut = 1; #1;
    chkEq("R5 switched out", LW'({fetchOk, icReqValid}), 0);
    doFetch(0, 32'h1234_5670, 1); intPending = 1; #1;
    chkEq("R5 int low bits zero", LW'({fetchOk, icReqValid}), 0);
    doFetch(0, 32'h1234_5672, 1); intPending = 1; #1;
    chkEq("R5 int low bits nonzero", LW'(fetchOk), 1);
  endtask

  task automatic tRefuse();
    logic [LW-1:0] d2 = {4{32'h5A5A_0002}};
    doFetch(1, 32'h2000_0004, 0);
    chkEq("R6 refused req", LW'(icReqValid), 1);
    chkEq("R6 refused ok", LW'(fetchOk), 0);
    doFetch(0, 32'h1234_5670, 1);
    chkEq("R6 blocked", LW'(icBlocked), 1);
    chkEq("R6 other thread refused", LW'({fetchOk, icReqValid}), 0);
    idle(); icRetry = 1; icReqReady = 0; #1;
    chkEq("R7 replay addr", LW'(icReqAddr), LW'(32'h2000_0000));
    chkEq("R7 replay tag", LW'({icReqValid, icReqTag}), LW'(3'b110));
    idle(); icRetry = 1; icReqReady = 1; #1;
    chkEq("R7 still blocked", LW'(icBlocked), 1);
    chkEq("R7 replay again", LW'(icReqValid), 1);
    idle();
    chkEq("R7 unblocked", LW'(icBlocked), 0);
    doRsp(2'b10, d2);
    idle(); fetchTid = 1; #1;
    chkEq("R10 thread1 data", lineRdData, d2);
  endtask

  task automatic tSquashSlot();
    doFetch(1, 32'h3000_0000, 0);
    idle(); squashValid = 1; squashTid = 1; #1;
    idle();
    chkEq("R9 blocked kept", LW'(icBlocked), 1);
    icRetry = 1; #1;
    chkEq("R8 R9 no replay", LW'(icReqValid), 0);
    idle();
    chkEq("R8 unblocked", LW'(icBlocked), 0);
    chkEq("R9 buffer invalid", LW'(lineValidVec[1]), 0);
  endtask

  task automatic tStale();
    doFetch(0, 32'h4000_0000, 1);
    chkEq("R2 tag seq0", LW'(icReqTag), LW'(2'b00));
    idle(); squashValid = 1; squashTid = 0; #1;
    doRsp(2'b00, {4{32'hDEAD_0000}});
    idle();
    chkEq("R11 not waiting", LW'(lineValidVec[0]), 0);
    doFetch(0, 32'h4000_0000, 1);
    chkEq("R9 seq flipped", LW'(icReqTag), LW'(2'b01));
    doRsp(2'b00, {4{32'hDEAD_0001}});
    idle();
    chkEq("R11 seq mismatch", LW'(lineValidVec[0]), 0);
    doRsp(2'b01, {4{32'hC0DE_0001}});
    idle();
    chkEq("R10 fresh seq accepted", lineRdData, {4{32'hC0DE_0001}});
  endtask

  task automatic tPriority();
    doFetch(1, 32'h5000_0000, 1); squashValid = 1; squashTid = 1; #1;
    chkEq("R12 fetch squashed", LW'({fetchOk, icReqValid}), 0);
    doFetch(1, 32'h5000_0000, 1);
    chkEq("R12 tag after squashes", LW'({icReqValid, icReqTag}), LW'(3'b110));
    doRsp(2'b10, {4{32'hBEEF_0000}}); squashValid = 1; squashTid = 1; #1;
    idle();
    chkEq("R12 response dropped", LW'(lineValidVec[1]), 0);
  endtask

  initial begin
    rstN = 0;
    fetchReq = 0; fetchTid = 0; fetchAddr = '0; switchedOut = 0; intPending = 0;
    squashValid = 0; squashTid = 0; icReqReady = 1; icRetry = 0;
    icRspValid = 0; icRspTag = '0; icRspData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    idle();
    tReset();
    tMissHit();
    tInhibit();
    tRefuse();
    tSquashSlot();
    tStale();
    tPriority();
    idle();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule